// File: doc/BRIEF.md
# Parallel capture engine

This block takes in parallel data from an external source and stores it as 32-bit words in on-chip RAM. It uses a write port of its own, so the host processor never waits for it. A strobe input from the external side marks when data is valid. The engine synchronises the strobe to the system clock and detects the selected edge type. It waits a programmed number of system cycles, then samples the data bus. In 8-bit and 16-bit modes, the samples are packed into a word before the RAM write is requested.

Storage alternates between two banks in ping-pong fashion. Each bank has a base address. A shared per-bank length sets how many words fill a bank. When a bank is full, a completion flag fires and writing moves to the other bank, starting again at that bank's base. A separate transfer counter bounds the total number of words stored. When it runs out, the engine goes idle until the next start pulse. The engine reports two errors: a word that completes while the previous write is still waiting for a grant, and a qualifying strobe edge that arrives while capture is not enabled.

Top module: `pcap_engine`

## Requirements
- R1: While reset is asserted, `wr_req`, `wr_be` and all five flag outputs are zero.
- R2: With `cfg_wsel`=0 (8-bit), each sample takes `din[7:0]`. Four samples form one word, with the first sample in bits 7:0 and the fourth in bits 31:24. The request rises one cycle after the fourth sample.
- R3: With `cfg_wsel`=1 (16-bit), each sample takes `din[15:0]`. Two samples form one word, with the first sample in bits 15:0.
- R4: With `cfg_wsel`=2 (32-bit), every sample is a full word.
- R5: A strobe rise qualifies only when `cfg_rise` is 1, and a strobe fall qualifies only when `cfg_fall` is 1. Setting both bits makes both edges qualify.
- R6: An edge is detected in the third system cycle after the strobe changes (two synchroniser stages plus one history stage). The sample is taken `cfg_delay` cycles (0 to 15) after detection. Edges that arrive while a delay is still counting are ignored.
- R7: A request presents `wr_addr`, starting at `cfg_base0` after `start`. The address advances by one on each granted write (`wr_req` and `wr_gnt` high together). `wr_be` is 4'hF while `wr_req` is high and 0 otherwise.
- R8: After `cfg_len` granted writes in a bank, `irq_done0` (bank 0) or `irq_done1` (bank 1) pulses for one cycle. Writing then continues in the other bank at its base address.
- R9: A word that completes while a request is pending and not granted is dropped, and `irq_ovr` pulses for one cycle. If the grant arrives in that same cycle, the word is accepted and no error is flagged. A pending request holds its address and data until it is granted.
- R10: A qualifying edge while `cap_en` is low, or while the engine is idle, pulses `irq_enerr` for one cycle and causes no sample.
- R11: The transfer counter loads `cfg_xfer` on `start` and decrements on each granted write. When it reaches zero, `irq_xfer_uf` pulses for one cycle, the engine goes idle, and no word completed in that cycle is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wsel | input | 2 | Sample width: 0 = 8, 1 = 16, 2 = 32 bits |
| cfg_rise | input | 1 | Rising strobe edge qualifies |
| cfg_fall | input | 1 | Falling strobe edge qualifies |
| cfg_delay | input | DLYW | Cycles from edge detection to sampling |
| cfg_base0 | input | AW | Bank 0 start word address |
| cfg_base1 | input | AW | Bank 1 start word address |
| cfg_len | input | LW | Words per bank (at least 1) |
| cfg_xfer | input | XW | Total words per transfer |
| start | input | 1 | Loads the counters and arms the engine |
| cap_en | input | 1 | Capture enable |
| strb | input | 1 | External capture strobe |
| din | input | 32 | External parallel data |
| wr_gnt | input | 1 | RAM write grant |
| wr_req | output | 1 | RAM write request |
| wr_addr | output | AW | RAM word address |
| wr_data | output | 32 | RAM write data |
| wr_be | output | 4 | Byte enables |
| irq_done0 | output | 1 | Bank 0 filled |
| irq_done1 | output | 1 | Bank 1 filled |
| irq_ovr | output | 1 | Overrun error |
| irq_enerr | output | 1 | Capture-enable error |
| irq_xfer_uf | output | 1 | Transfer count exhausted |

## Verification
Two pairs of events can land in the same cycle. In the first, a word completes in the very cycle in which the pending request is granted. This must be accepted without an overrun, while one cycle earlier it would have been dropped. In the second, the grant that fills a bank is also the grant that exhausts the transfer counter. The bench provokes the first pair with a pseudo-random grant against a strobe that toggles every two cycles. It provokes the second by making the transfer length an exact multiple of the bank length. A behavioural model built on a byte queue decides each cycle which flags must fire, and the bench compares every output against it on every clock.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int LANES = 4;
  localparam int WORDW = LANES * 8;

  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2
  } wsel_e;

  // Place one sample into the partial word at lane position idx.
  function automatic logic [WORDW-1:0] lane_merge(input logic [WORDW-1:0] acc,
                                                  input logic [WORDW-1:0] din,
                                                  input logic [1:0] idx,
                                                  input logic [1:0] wsel);
    logic [WORDW-1:0] r;
    r = acc;
    case (wsel)
      WSEL_8:  r[{idx, 3'b000} +: 8]        = din[7:0];
      WSEL_16: r[{idx[1], 4'b0000} +: 16]   = din[15:0];
      default: r = din;
    endcase
    return r;
  endfunction

  // The word is complete once this sample lands in the top lane.
  function automatic logic lane_full(input logic [1:0] idx, input logic [1:0] wsel);
    case (wsel)
      WSEL_8:  return idx == 2'd3;
      WSEL_16: return idx[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] lane_next(input logic [1:0] idx, input logic [1:0] wsel);
    if (lane_full(idx, wsel)) return 2'd0;
    return (wsel == WSEL_8) ? idx + 2'd1 : idx + 2'd2;
  endfunction
endpackage

// File: rtl/pcap_trigger.sv
module pcap_trigger #(
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strb,
  input  logic            rise_en,
  input  logic            fall_en,
  input  logic            en_ok,
  input  logic [DLYW-1:0] delay,
  output logic            edge_evt,
  output logic            enerr_evt,
  output logic            sample_evt
);
  logic [2:0]      sync_q;
  logic [DLYW-1:0] cnt_q;
  logic            busy, accept;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], strb};

  assign edge_evt  = (rise_en & sync_q[1] & ~sync_q[2]) |
                     (fall_en & ~sync_q[1] & sync_q[2]);
  assign busy      = (cnt_q != '0);
  assign enerr_evt = edge_evt & ~en_ok;
  assign accept    = edge_evt & en_ok & ~busy;
  assign sample_evt = (accept & (delay == '0)) | (cnt_q == DLYW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        cnt_q <= '0;
    else if (accept && delay != '0)    cnt_q <= delay;
    else if (busy)                     cnt_q <= cnt_q - DLYW'(1);
endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
  import pcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic [1:0]       wsel,
  input  logic [WORDW-1:0] din,
  output logic             word_vld,
  output logic [WORDW-1:0] word
);
  logic [WORDW-1:0] acc_q;
  logic [1:0]       idx_q;

  assign word     = lane_merge(acc_q, din, idx_q, wsel);
  assign word_vld = sample & lane_full(idx_q, wsel);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (sample) begin
      acc_q <= word;
      idx_q <= lane_next(idx_q, wsel);
    end
endmodule

// File: rtl/pcap_addr.sv
module pcap_addr #(
  parameter int AW = 12,
  parameter int LW = 10,
  parameter int XW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          commit,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic [LW-1:0] len,
  input  logic [XW-1:0] xfer_len,
  output logic [AW-1:0] addr,
  output logic          active,
  output logic          done0,
  output logic          done1,
  output logic          xfer_end
);
  logic          bank_q;
  logic [LW-1:0] rem_q;
  logic [XW-1:0] xcnt_q;
  logic          last;

  assign last     = (rem_q == LW'(1));
  assign done0    = commit & last & ~bank_q;
  assign done1    = commit & last & bank_q;
  assign xfer_end = commit & (xcnt_q == XW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bank_q <= 1'b0;
      rem_q  <= '0;
      xcnt_q <= '0;
      addr   <= '0;
      active <= 1'b0;
    end else if (start) begin
      bank_q <= 1'b0;
      addr   <= base0;
      rem_q  <= len;
      xcnt_q <= xfer_len;
      active <= (xfer_len != '0);
    end else if (commit) begin
      xcnt_q <= xcnt_q - XW'(1);
      if (xfer_end) active <= 1'b0;
      if (last) begin
        bank_q <= ~bank_q;
        addr   <= bank_q ? base0 : base1;
        rem_q  <= len;
      end else begin
        addr   <= addr + AW'(1);
        rem_q  <= rem_q - LW'(1);
      end
    end
endmodule

// File: rtl/pcap_engine.sv
module pcap_engine
  import pcap_pkg::*;
#(
  parameter int AW   = 12,
  parameter int LW   = 10,
  parameter int XW   = 16,
  parameter int DLYW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_wsel,
  input  logic             cfg_rise,
  input  logic             cfg_fall,
  input  logic [DLYW-1:0]  cfg_delay,
  input  logic [AW-1:0]    cfg_base0,
  input  logic [AW-1:0]    cfg_base1,
  input  logic [LW-1:0]    cfg_len,
  input  logic [XW-1:0]    cfg_xfer,
  input  logic             start,
  input  logic             cap_en,
  input  logic             strb,
  input  logic [WORDW-1:0] din,
  input  logic             wr_gnt,
  output logic             wr_req,
  output logic [AW-1:0]    wr_addr,
  output logic [WORDW-1:0] wr_data,
  output logic [LANES-1:0] wr_be,
  output logic             irq_done0,
  output logic             irq_done1,
  output logic             irq_ovr,
  output logic             irq_enerr,
  output logic             irq_xfer_uf
);
  // Named internal events, visible to the bound checker.
  logic             active, en_ok, commit, stall;
  logic             edge_evt, enerr_evt, sample_evt;
  logic             word_vld, word_take, ovr_evt;
  logic             done0, done1, xfer_end;
  logic [WORDW-1:0] word;

  assign en_ok     = cap_en & active;
  assign commit    = wr_req & wr_gnt;
  assign stall     = wr_req & ~wr_gnt;
  assign word_take = word_vld & ~xfer_end;
  assign ovr_evt   = word_vld & stall;
  assign wr_be     = {LANES{wr_req}};

  pcap_trigger #(.DLYW(DLYW)) u_trig (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rise_en(cfg_rise), .fall_en(cfg_fall),
    .en_ok(en_ok), .delay(cfg_delay), .edge_evt(edge_evt), .enerr_evt(enerr_evt),
    .sample_evt(sample_evt)
  );

  pcap_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(start), .sample(sample_evt & active),
    .wsel(cfg_wsel), .din(din), .word_vld(word_vld), .word(word)
  );

  pcap_addr #(.AW(AW), .LW(LW), .XW(XW)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .commit(commit),
    .base0(cfg_base0), .base1(cfg_base1), .len(cfg_len), .xfer_len(cfg_xfer),
    .addr(wr_addr), .active(active), .done0(done0), .done1(done1), .xfer_end(xfer_end)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_req      <= 1'b0;
      wr_data     <= '0;
      irq_done0   <= 1'b0;
      irq_done1   <= 1'b0;
      irq_ovr     <= 1'b0;
      irq_enerr   <= 1'b0;
      irq_xfer_uf <= 1'b0;
    end else begin
      irq_done0   <= done0;
      irq_done1   <= done1;
      irq_ovr     <= ovr_evt;
      irq_enerr   <= enerr_evt;
      irq_xfer_uf <= xfer_end;
      if (word_take && !stall) begin
        wr_req  <= 1'b1;
        wr_data <= word;
      end else if (commit) begin
        wr_req  <= 1'b0;
      end
    end
endmodule

// File: rtl/pcap_engine_chk.sv
module pcap_engine_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          wr_gnt,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [3:0]    wr_be,
  input logic          irq_done0,
  input logic          irq_done1,
  input logic          irq_ovr,
  input logic          irq_enerr,
  input logic          irq_xfer_uf,
  input logic [AW-1:0] cfg_base0,
  input logic [AW-1:0] cfg_base1,
  input logic          en_ok,
  input logic          active
);
  assert_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_be == (wr_req ? 4'hF : 4'h0));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_gnt) |=> (irq_done0 || irq_done1 || wr_addr == AW'($past(wr_addr) + 1'b1)));

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_done0, irq_done1}));

  assert_done0_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done0 |-> wr_addr == cfg_base1);

  assert_done1_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done1 |-> wr_addr == cfg_base0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_data) && $stable(wr_addr)));

  assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> $past(wr_req && !wr_gnt));

  assert_enerr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enerr |-> !$past(en_ok));

  assert_uf_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_xfer_uf |-> (!active && $past(wr_req && wr_gnt)));
endmodule

bind pcap_engine pcap_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_gnt(wr_gnt), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_be(wr_be), .irq_done0(irq_done0), .irq_done1(irq_done1),
  .irq_ovr(irq_ovr), .irq_enerr(irq_enerr), .irq_xfer_uf(irq_xfer_uf),
  .cfg_base0(cfg_base0), .cfg_base1(cfg_base1), .en_ok(en_ok), .active(active)
);

// File: tb/test_pcap_engine.sv
module test_pcap_engine;
  localparam int AW = 12, LW = 10, XW = 16, DLYW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_wsel = 2'd0;
  logic cfg_rise = 1'b0, cfg_fall = 1'b0;
  logic [DLYW-1:0] cfg_delay = '0;
  logic [AW-1:0] cfg_base0 = '0, cfg_base1 = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [XW-1:0] cfg_xfer = '0;
  logic start = 1'b0, cap_en = 1'b0, strb = 1'b0, wr_gnt = 1'b0;
  logic [31:0] din = 32'h1234_5678;
  logic wr_req, irq_done0, irq_done1, irq_ovr, irq_enerr, irq_xfer_uf;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;

  int n_chk = 0, n_err = 0;
  bit finished = 0, cmp_on = 0, rnd_gnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  pcap_engine #(.AW(AW), .LW(LW), .XW(XW), .DLYW(DLYW)) i_pcap_engine (
    .clk(clk), .rst_n(rst_n), .cfg_wsel(cfg_wsel), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
    .cfg_delay(cfg_delay), .cfg_base0(cfg_base0), .cfg_base1(cfg_base1), .cfg_len(cfg_len),
    .cfg_xfer(cfg_xfer), .start(start), .cap_en(cap_en), .strb(strb), .din(din),
    .wr_gnt(wr_gnt), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .irq_done0(irq_done0), .irq_done1(irq_done1), .irq_ovr(irq_ovr),
    .irq_enerr(irq_enerr), .irq_xfer_uf(irq_xfer_uf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: strobe history queue, byte queue, plain counters.
  bit          hist[$];
  logic [7:0]  m_bytes[$];
  int          m_cnt;
  logic        m_req, m_active, m_bank;
  logic [31:0] m_data;
  logic [AW-1:0] m_addr;
  logic [LW-1:0] m_rem;
  logic [XW-1:0] m_x;
  logic m_d0, m_d1, m_ovr, m_enerr, m_uf;

  always @(posedge clk) begin
    logic a, b, hit, en, busy, smp, nw, cm, xend;
    logic [31:0] w;
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_bytes.delete();
      m_cnt = 0; m_req = 0; m_active = 0; m_bank = 0; m_data = 0; m_addr = 0;
      m_rem = 0; m_x = 0; m_d0 = 0; m_d1 = 0; m_ovr = 0; m_enerr = 0; m_uf = 0;
    end else begin
      a = hist[hist.size()-2];
      b = hist[hist.size()-3];
      hit = (cfg_rise && a && !b) || (cfg_fall && !a && b);
      en = cap_en && m_active;
      busy = (m_cnt > 0);
      smp = 0; nw = 0; w = 0;
      m_d0 = 0; m_d1 = 0; m_ovr = 0; m_enerr = 0; m_uf = 0;
      if (busy) begin
        m_cnt--;
        if (m_cnt == 0) smp = 1;
      end
      if (hit && !en) m_enerr = 1;
      else if (hit && !busy) begin
        if (cfg_delay == 0) smp = 1;
        else m_cnt = int'(cfg_delay);
      end
      if (smp && m_active) begin
        case (cfg_wsel)
          2'd0: m_bytes.push_back(din[7:0]);
          2'd1: begin m_bytes.push_back(din[7:0]); m_bytes.push_back(din[15:8]); end
          default: for (int k = 0; k < 4; k++) m_bytes.push_back(din[8*k +: 8]);
        endcase
        if (m_bytes.size() >= 4) begin
          w = {m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]};
          repeat (4) void'(m_bytes.pop_front());
          nw = 1;
        end
      end
      cm = m_req && wr_gnt;
      xend = cm && (m_x == 1);
      if (nw && m_req && !wr_gnt) m_ovr = 1;
      if (cm) begin
        m_x = m_x - 1'b1;
        if (xend) begin m_active = 0; m_uf = 1; end
        if (m_rem == 1) begin
          if (!m_bank) m_d0 = 1; else m_d1 = 1;
          m_bank = !m_bank;
          m_addr = m_bank ? cfg_base1 : cfg_base0;
          m_rem = cfg_len;
        end else begin
          m_addr = m_addr + 1'b1;
          m_rem = m_rem - 1'b1;
        end
      end
      if (nw && !xend && !(m_req && !wr_gnt)) begin
        m_req = 1; m_data = w;
      end else if (cm) m_req = 0;
      if (start) begin
        m_bank = 0; m_addr = cfg_base0; m_rem = cfg_len; m_x = cfg_xfer;
        m_active = (cfg_xfer != 0);
        m_bytes.delete();
      end
      hist.push_back(strb);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  // Compare every output against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on && !finished) begin
      chk("R5 R6 wr_req", {31'd0, wr_req}, {31'd0, m_req});
      chk("R7 wr_be", {28'd0, wr_be}, m_req ? 32'hF : 32'h0);
      if (m_req) begin
        chk("R7 wr_addr", {20'd0, wr_addr}, {20'd0, m_addr});
        case (cfg_wsel)
          2'd0: chk("R2 wr_data", wr_data, m_data);
          2'd1: chk("R3 wr_data", wr_data, m_data);
          default: chk("R4 wr_data", wr_data, m_data);
        endcase
      end
      chk("R8 irq_done0", {31'd0, irq_done0}, {31'd0, m_d0});
      chk("R8 irq_done1", {31'd0, irq_done1}, {31'd0, m_d1});
      chk("R9 irq_ovr", {31'd0, irq_ovr}, {31'd0, m_ovr});
      chk("R10 irq_enerr", {31'd0, irq_enerr}, {31'd0, m_enerr});
      chk("R11 irq_xfer_uf", {31'd0, irq_xfer_uf}, {31'd0, m_uf});
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_gnt) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_gnt = lfsr[0];
      end
    end
  endtask

  task automatic toggle(input int count, input int gap);
    for (int i = 0; i < count; i++) begin
      strb = ~strb;
      din = din * 32'h0019_660D + 32'h3C6E_F35F;
      wait_cyc(gap);
    end
  endtask

  task automatic arm(input logic [LW-1:0] len, input logic [XW-1:0] xf);
    cfg_len = len; cfg_xfer = xf;
    start = 1'b1;
    wait_cyc(1);
    start = 1'b0;
    wait_cyc(2);
  endtask

  initial begin
    wait_cyc(3);
    // R1: outputs quiet while reset is held
    chk("R1 wr_req", {31'd0, wr_req}, 32'd0);
    chk("R1 wr_be", {28'd0, wr_be}, 32'd0);
    chk("R1 flags", {27'd0, irq_done0, irq_done1, irq_ovr, irq_enerr, irq_xfer_uf}, 32'd0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_cyc(2);

    // R2 R5 R7 R8: 8-bit samples on rising edges, bank 0 fills after 3 words
    cfg_base0 = 12'h010; cfg_base1 = 12'h200;
    cfg_wsel = 2'd0; cfg_rise = 1; cfg_fall = 0; cfg_delay = 0;
    cap_en = 1; wr_gnt = 1;
    arm(10'd3, 16'd100);
    toggle(24, 8);

    // R3 R5 R6: 16-bit samples on both edges with delay 5
    cfg_wsel = 2'd1; cfg_fall = 1; cfg_delay = 4'd5;
    toggle(10, 12);

    // R4 R5 R6: 32-bit samples on falling edges only, delay 15
    cfg_wsel = 2'd2; cfg_rise = 0; cfg_delay = 4'd15;
    toggle(6, 24);

    // R10: edges with capture disabled
    cfg_delay = 0; cfg_rise = 1;
    cap_en = 0;
    toggle(4, 8);
    cap_en = 1;

    // R9: no grant, words pile up and overrun
    wr_gnt = 0;
    toggle(4, 6);
    wr_gnt = 1;
    wait_cyc(6);

    // R9: pseudo-random grant against a fast strobe (grant and word in the same cycle)
    rnd_gnt = 1;
    toggle(80, 2);
    toggle(40, 3);
    rnd_gnt = 0; wr_gnt = 1;
    wait_cyc(8);

    // R8 R11: bank fills and transfer ends on the same grant, then edges hit an idle engine
    cfg_delay = 4'd2;
    arm(10'd4, 16'd8);
    toggle(12, 8);
    wait_cyc(8);

    // R6: long delay with edges arriving during the count
    cfg_wsel = 2'd0; cfg_delay = 4'd10;
    arm(10'd5, 16'd200);
    toggle(32, 4);
    wait_cyc(20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule